// File: doc/BRIEF.md
# Paired-Register I2C Target

This block is an I2C target that gives a controller access to a bank of eight byte-wide registers, arranged as four pairs. The registers themselves sit on the user side of the block. The block samples SCL and SDA with its own system clock and finds start, repeated start and stop conditions. It recognises its 7-bit address and records the command byte as a register pointer. It then moves any number of data bytes in either direction. Each write byte is handed out with a one-cycle write strobe. For each read byte, the block fetches the value from the user side with a one-cycle read strobe.

The pointer does not count through the register map. After every data byte it moves to the other register of its pair, so the pointer only ever changes in bit 0. Indices 0 and 1 hold the read-only input pair: the block acknowledges writes to them but passes none of those writes on. The SDA output is an open-drain enable, where 1 pulls the line low and 0 releases it. The system clock must run at least 16 times faster than SCL, which may reach 400 kHz.

Top module: `i2cPairTarget`

## Requirements
- R1: The target answers only to address {0100, strapAddr[2:0]} (address bits 7..1 of the first byte after a start); bit 0 of that byte is R/W, with 0 meaning write. On a match it pulls SDA low in the acknowledge slot. On a mismatch it leaves SDA released and ignores all bytes until the next start.
- R2: In a write transfer, the byte after the address is the command byte. Its bits 2..0 load the register pointer, and its bits 7..3 are ignored. The target acknowledges it.
- R3: After each data byte, read or write, the pointer flips bit 0 and so moves to the partner register of its pair.
- R4: Every data byte written is acknowledged. Each one raises wrStb for exactly one cycle, with wrData holding the byte and regIdx the pointer value before the flip. A transfer may carry any number of such bytes.
- R5: Data bytes written while the pointer is 0 or 1 are acknowledged, but no wrStb pulse is raised for them.
- R6: After a repeated start with R/W=1, the target sends rdData, MSB first, from the register named by the last command byte. Later bytes alternate within the pair. Each byte is fetched with a one-cycle rdStb pulse, during which regIdx names the register being read.
- R7: When the controller does not acknowledge a read byte, the target releases SDA and raises no further rdStb until a new start.
- R8: A stop condition at any bit returns the target to idle with SDA released and no strobe raised.
- R9: sdaDrvLow changes only in the cycle after the synchronised SCL is seen low, or after a start or stop is detected.
- R10: During and right after reset, sdaDrvLow, wrStb and rdStb are 0 and regIdx is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line level |
| sdaIn | input | 1 | Serial data line level (as seen on the bus) |
| strapAddr | input | 3 | Low three bits of the target address |
| sdaDrvLow | output | 1 | 1 pulls SDA low, 0 releases it |
| regIdx | output | 3 | Register pointer presented to the user side |
| wrData | output | 8 | Byte to be written |
| wrStb | output | 1 | One-cycle write strobe |
| rdData | input | 8 | Contents of the register named by regIdx |
| rdStb | output | 1 | One-cycle strobe marking the cycle rdData is taken |

## Verification
Two things happen on the same clock edge at the end of every write byte: the write strobe is issued, and the pointer flips to the partner register. The strobe must carry the index from before the flip, and the next byte must land in the partner. Multi-byte writes are started at every one of the eight command values, including ones with junk in the upper command bits. A bench-side register model is then read back with alternating reads. A write landing one register off, or a stray strobe at the input pair, shows up as a wrong readback value or a wrong strobe count.

// File: rtl/i2cPairPkg.sv
package i2cPairPkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_ADDR,
    S_ADDR_ACK,
    S_CMD,
    S_CMD_ACK,
    S_WR,
    S_WR_ACK,
    S_RD,
    S_RD_ACK
  } ctrlState_t;

  // Strobes from control to datapath, at most a few per cycle.
  typedef struct packed {
    logic shiftIn;     // sample SDA into the shift register
    logic loadPtr;     // take pointer from received command byte
    logic flipPtr;     // move to the partner register
    logic userWrite;   // hand received byte to the user side
    logic loadTx;      // fetch a byte to send
    logic shiftTx;     // present the next transmit bit
    logic driveAck;    // pull SDA low for acknowledge
    logic releaseSda;  // let SDA go
  } dpStrobe_t;

endpackage

// File: rtl/i2cLineSync.sv
module i2cLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclSync,
  output logic sdaSync,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[0] <= 1'b1;
            sdaPipe[0] <= 1'b1;
          end else begin
            sclPipe[0] <= sclIn;
            sdaPipe[0] <= sdaIn;
          end
        end
      end else begin : gNext
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            sclPipe[g] <= 1'b1;
            sdaPipe[g] <= 1'b1;
          end else begin
            sclPipe[g] <= sclPipe[g-1];
            sdaPipe[g] <= sdaPipe[g-1];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  assign sclSync  = sclPipe[STAGES-1];
  assign sdaSync  = sdaPipe[STAGES-1];
  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

endmodule

// File: rtl/i2cPairCtrl.sv
module i2cPairCtrl
  import i2cPairPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int STRAP_W = 3,
  parameter int ADDR_HI = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclRise,
  input  logic               sclFall,
  input  logic               startDet,
  input  logic               stopDet,
  input  logic               sdaSync,
  input  logic [DATA_W-1:0]  rxByte,
  input  logic [STRAP_W-1:0] strapAddr,
  output dpStrobe_t          stb
);

  localparam int HI_W  = DATA_W - 1 - STRAP_W;
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [HI_W-1:0]  addrHi  = HI_W'(ADDR_HI);
  localparam logic [CNT_W-1:0] fullCnt = CNT_W'(DATA_W);

  ctrlState_t state, stateNxt;
  logic [CNT_W-1:0] bitCnt, bitCntNxt;
  logic rwBit, rwBitNxt;
  logic mAck, mAckNxt;
  logic addrHit;

  assign addrHit = (rxByte[DATA_W-1:1] == {addrHi, strapAddr});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_IDLE;
      bitCnt <= '0;
      rwBit  <= 1'b0;
      mAck   <= 1'b0;
    end else begin
      state  <= stateNxt;
      bitCnt <= bitCntNxt;
      rwBit  <= rwBitNxt;
      mAck   <= mAckNxt;
    end
  end

  always_comb begin
    stateNxt  = state;
    bitCntNxt = bitCnt;
    rwBitNxt  = rwBit;
    mAckNxt   = mAck;
    stb       = '0;
    if (startDet) begin
      stateNxt       = S_ADDR;
      bitCntNxt      = '0;
      stb.releaseSda = 1'b1;
    end else if (stopDet) begin
      stateNxt       = S_IDLE;
      bitCntNxt      = '0;
      stb.releaseSda = 1'b1;
    end else begin
      unique case (state)
        S_IDLE: ;
        S_ADDR, S_CMD, S_WR: begin
          if (sclRise && bitCnt != fullCnt) begin
            stb.shiftIn = 1'b1;
            bitCntNxt   = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == fullCnt) begin
            if (state == S_ADDR) begin
              if (addrHit) begin
                stb.driveAck = 1'b1;
                rwBitNxt     = rxByte[0];
                stateNxt     = S_ADDR_ACK;
              end else begin
                stateNxt = S_IDLE;
              end
            end else if (state == S_CMD) begin
              stb.loadPtr  = 1'b1;
              stb.driveAck = 1'b1;
              stateNxt     = S_CMD_ACK;
            end else begin
              stb.userWrite = 1'b1;
              stb.flipPtr   = 1'b1;
              stb.driveAck  = 1'b1;
              stateNxt      = S_WR_ACK;
            end
          end
        end
        S_ADDR_ACK: begin
          if (sclFall) begin
            bitCntNxt = '0;
            if (rwBit) begin
              stb.loadTx = 1'b1;
              stateNxt   = S_RD;
            end else begin
              stb.releaseSda = 1'b1;
              stateNxt       = S_CMD;
            end
          end
        end
        S_CMD_ACK, S_WR_ACK: begin
          if (sclFall) begin
            stb.releaseSda = 1'b1;
            bitCntNxt      = '0;
            stateNxt       = S_WR;
          end
        end
        S_RD: begin
          if (sclRise) begin
            bitCntNxt = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == fullCnt) begin
              stb.releaseSda = 1'b1;
              stb.flipPtr    = 1'b1;
              stateNxt       = S_RD_ACK;
            end else begin
              stb.shiftTx = 1'b1;
            end
          end
        end
        S_RD_ACK: begin
          if (sclRise) begin
            mAckNxt = ~sdaSync;
          end else if (sclFall) begin
            bitCntNxt = '0;
            if (mAck) begin
              stb.loadTx = 1'b1;
              stateNxt   = S_RD;
            end else begin
              stateNxt = S_IDLE;
            end
          end
        end
        default: stateNxt = S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2cPairDatapath.sv
module i2cPairDatapath
  import i2cPairPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic              sdaSync,
  input  logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] rxByte,
  output logic [IDX_W-1:0]  regIdx,
  output logic [DATA_W-1:0] wrData,
  output logic              wrStb,
  output logic              rdStb,
  output logic              sdaDrvLow
);

  logic [DATA_W-1:0] shiftReg;
  logic [IDX_W-1:0]  ptr;
  logic              drvLow;
  logic              ptrWritable;

  assign ptrWritable = |ptr[IDX_W-1:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (stb.loadTx) begin
      shiftReg <= rdData;
    end else if (stb.shiftTx) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b0};
    end else if (stb.shiftIn) begin
      shiftReg <= {shiftReg[DATA_W-2:0], sdaSync};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (stb.loadPtr) begin
      ptr <= shiftReg[IDX_W-1:0];
    end else if (stb.flipPtr) begin
      ptr <= ptr ^ IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      drvLow <= 1'b0;
    end else if (stb.releaseSda) begin
      drvLow <= 1'b0;
    end else if (stb.driveAck) begin
      drvLow <= 1'b1;
    end else if (stb.loadTx) begin
      drvLow <= ~rdData[DATA_W-1];
    end else if (stb.shiftTx) begin
      drvLow <= ~shiftReg[DATA_W-2];
    end
  end

  assign rxByte    = shiftReg;
  assign wrData    = shiftReg;
  assign regIdx    = ptr;
  assign wrStb     = stb.userWrite & ptrWritable;
  assign rdStb     = stb.loadTx;
  assign sdaDrvLow = drvLow;

endmodule

// File: rtl/i2cPairTarget.sv
module i2cPairTarget
  import i2cPairPkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 3,
  parameter int STRAP_W     = 3,
  parameter int ADDR_HI     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapAddr,
  output logic               sdaDrvLow,
  output logic [IDX_W-1:0]   regIdx,
  output logic [DATA_W-1:0]  wrData,
  output logic               wrStb,
  input  logic [DATA_W-1:0]  rdData,
  output logic               rdStb
);

  logic sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic [DATA_W-1:0] rxByte;
  dpStrobe_t stb;

  i2cLineSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclSync(sclSync), .sdaSync(sdaSync), .sclRise(sclRise),
    .sclFall(sclFall), .startDet(startDet), .stopDet(stopDet)
  );

  i2cPairCtrl #(.DATA_W(DATA_W), .STRAP_W(STRAP_W), .ADDR_HI(ADDR_HI)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaSync(sdaSync),
    .rxByte(rxByte), .strapAddr(strapAddr), .stb(stb)
  );

  i2cPairDatapath #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .sdaSync(sdaSync), .rdData(rdData),
    .rxByte(rxByte), .regIdx(regIdx), .wrData(wrData), .wrStb(wrStb),
    .rdStb(rdStb), .sdaDrvLow(sdaDrvLow)
  );

endmodule

// File: rtl/i2cPairChecker.sv
module i2cPairChecker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclSync,
  input logic             startDet,
  input logic             stopDet,
  input logic             sdaDrvLow,
  input logic             wrStb,
  input logic             rdStb,
  input logic [IDX_W-1:0] regIdx
);

  // R9: drive level moves only after SCL seen low or a bus condition
  p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sdaDrvLow != $past(sdaDrvLow)) |-> (!$past(sclSync) || $past(startDet) || $past(stopDet)));

  // R5: no write strobe while pointing at the input pair
  p_no_input_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> (regIdx[IDX_W-1:1] != '0));

  // R4: write strobe lasts one cycle
  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> !wrStb);

  // R3: pointer moves to partner after a written byte
  p_ptr_flip_r3: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> (regIdx == ($past(regIdx) ^ IDX_W'(1))));

  // R8: stop leaves SDA released
  p_stop_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDrvLow);

  // R6: read and write strobes never coincide
  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStb && rdStb));

endmodule

bind i2cPairTarget i2cPairChecker #(.IDX_W(IDX_W)) uChk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .startDet(startDet),
  .stopDet(stopDet), .sdaDrvLow(sdaDrvLow), .wrStb(wrStb),
  .rdStb(rdStb), .regIdx(regIdx)
);

// File: tb/tb_i2cPairTarget.sv
module tb_i2cPairTarget;

  localparam int QTR = 10;  // system clocks per quarter SCL period

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaM = 1'b1;
  logic [2:0] strap = 3'b101;
  logic       sdaDrvLow;
  logic [2:0] regIdx;
  logic [7:0] wrData;
  logic       wrStb;
  logic [7:0] rdData;
  logic       rdStb;
  wire        sdaLine = sdaM & ~sdaDrvLow;

  i2cPairTarget dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .strapAddr(strap), .sdaDrvLow(sdaDrvLow), .regIdx(regIdx),
    .wrData(wrData), .wrStb(wrStb), .rdData(rdData), .rdStb(rdStb)
  );

  // User-side register bank
  logic [7:0] bank [8];
  logic [7:0] pins [2];
  logic [7:0] expReg [8];
  int wrCount = 0;
  int rdCount = 0;
  int sclHighFlips = 0;
  logic prevDrv = 1'b0;
  int checks = 0;
  int failures = 0;

  assign rdData = (regIdx[2:1] == 2'b00) ? pins[regIdx[0]] : bank[regIdx];

  always @(posedge clk) begin
    if (wrStb) begin
      bank[regIdx] <= wrData;
      wrCount <= wrCount + 1;
    end
    if (rdStb) rdCount <= rdCount + 1;
    // R9 monitor: drive changes while raw SCL has been high for a while
    if (sdaDrvLow != prevDrv && sclM) sclHighFlips <= sclHighFlips + 1;
    prevDrv <= sdaDrvLow;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic startC();
    sdaM = 1'b1; sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic restartC();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic stopC();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic writeBit(input logic b);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ(); waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b);
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    b = sdaLine; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(b);
    acked = ~b;
  endtask

  task automatic recvByte(input logic giveAck, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      readBit(b);
      v[i] = b;
    end
    writeBit(~giveAck);
  endtask

  function automatic logic [7:0] dataVal(input int c, input int k);
    return 8'((c * 37) + (k * 11) + 3);
  endfunction

  function automatic logic [7:0] expRead(input logic [2:0] idx);
    return (idx[2:1] == 2'b00) ? pins[idx[0]] : expReg[idx];
  endfunction

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] rv;
    int wBase;
    int rBase;
    for (int i = 0; i < 8; i++) begin
      bank[i] = 8'h00;
      expReg[i] = 8'h00;
    end
    pins[0] = 8'h3C;
    pins[1] = 8'hC3;

    repeat (5) @(negedge clk);
    // R10: reset state
    check(sdaDrvLow == 1'b0 && wrStb == 1'b0 && rdStb == 1'b0, "R10 strobes/drive in reset",
          {sdaDrvLow, wrStb, rdStb}, 0);
    check(regIdx == 3'd0, "R10 pointer in reset", regIdx, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(sdaDrvLow == 1'b0 && regIdx == 3'd0, "R10 after reset", {sdaDrvLow, regIdx}, 0);

    // R1: address sweep over all strap-sized low bits
    for (int a = 0; a < 8; a++) begin
      startC();
      sendByte({4'b0100, 3'(a), 1'b0}, ack);
      stopC();
      check(ack == (a == 5), "R1 address match", ack, (a == 5));
    end
    startC();
    sendByte({4'b0110, 3'b101, 1'b0}, ack);
    stopC();
    check(ack == 1'b0, "R1 wrong upper address bits", ack, 0);
    // R1: after a mismatch, a byte that looks like our address is ignored
    startC();
    sendByte({4'b0100, 3'b100, 1'b0}, ack);
    sendByte({4'b0100, 3'b101, 1'b0}, ack);
    stopC();
    check(ack == 1'b0, "R1 ignored until next start", ack, 0);

    // R2 R3 R4 R5: three-byte writes from every command value
    for (int c = 0; c < 8; c++) begin
      logic [2:0] idx;
      logic allAck;
      wBase = wrCount;
      allAck = 1'b1;
      startC();
      sendByte({4'b0100, strap, 1'b0}, ack);
      allAck &= ack;
      sendByte(c[0] ? (8'hF8 | 8'(c)) : 8'(c), ack);  // R2 junk in upper bits
      allAck &= ack;
      idx = 3'(c);
      for (int k = 0; k < 3; k++) begin
        sendByte(dataVal(c, k), ack);
        allAck &= ack;
        if (idx[2:1] != 2'b00) expReg[idx] = dataVal(c, k);
        idx = idx ^ 3'd1;
      end
      stopC();
      check(allAck == 1'b1, "R4 all write bytes acknowledged (R5 incl. input pair)", allAck, 1);
      check((wrCount - wBase) == ((c >= 2) ? 3 : 0), "R5 write strobe count",
            wrCount - wBase, (c >= 2) ? 3 : 0);
    end
    for (int i = 2; i < 8; i++)
      check(bank[i] == expReg[i], "R3 pair alternation of writes", bank[i], expReg[i]);

    // R6: reads alternating within the pair from every command value
    for (int c = 0; c < 8; c++) begin
      logic [2:0] idx;
      rBase = rdCount;
      startC();
      sendByte({4'b0100, strap, 1'b0}, ack);
      sendByte(8'(c), ack);
      restartC();
      sendByte({4'b0100, strap, 1'b1}, ack);
      check(ack == 1'b1, "R6 read address acknowledged", ack, 1);
      idx = 3'(c);
      for (int k = 0; k < 4; k++) begin
        recvByte(k < 3, rv);
        check(rv == expRead(idx), "R6 read data in pair order", rv, expRead(idx));
        idx = idx ^ 3'd1;
      end
      stopC();
      check((rdCount - rBase) == 4, "R6 read strobe count", rdCount - rBase, 4);
    end

    // R7: after NACK the target lets go of SDA
    rBase = rdCount;
    startC();
    sendByte({4'b0100, strap, 1'b1}, ack);
    recvByte(1'b0, rv);
    begin
      logic [7:0] extra;
      recvByte(1'b0, extra);
      check(extra == 8'hFF, "R7 SDA released after NACK", extra, 8'hFF);
    end
    stopC();
    check((rdCount - rBase) == 1, "R7 no fetch after NACK", rdCount - rBase, 1);

    // R8: stop in the middle of a data byte
    wBase = wrCount;
    startC();
    sendByte({4'b0100, strap, 1'b0}, ack);
    sendByte(8'd2, ack);
    for (int i = 0; i < 4; i++) writeBit(1'b0);
    stopC();
    repeat (4) @(negedge clk);
    check(sdaDrvLow == 1'b0 && wrStb == 1'b0, "R8 idle after early stop", sdaDrvLow, 0);
    check(wrCount == wBase, "R8 no write from partial byte", wrCount - wBase, 0);
    startC();
    sendByte({4'b0100, strap, 1'b0}, ack);
    sendByte(8'd3, ack);
    sendByte(8'h5A, ack);
    stopC();
    expReg[3] = 8'h5A;
    check(bank[3] == 8'h5A, "R8 normal transfer after early stop", bank[3], 8'h5A);

    // R9: no drive change while SCL was high
    check(sclHighFlips == 0, "R9 SDA changes only with SCL low", sclHighFlips, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule